// File: doc/BRIEF.md
# Serial EEPROM Host Controller

This block sits on the host side of a three-wire serial EEPROM link. A client logic block presents one request: a command code, a word address, a write word and, for reads, a word count. The controller then builds the instruction frame and shifts it out on chip select, serial clock and data lines. For reads it captures the words that come back from the device. For programming commands it checks for completion.

Every serial timing quantity is counted in system clock cycles and set by a parameter. These are the clock half-period, the chip-select low gap and the poll limit. The client sees a busy flag while a command runs, a one-cycle done pulse at its end, a valid strobe with each read word, and an error flag when the device never reports ready.

Top module: `eeSerialHost`

## Requirements
- R1: While reset is asserted and in the first cycle after it, csOut, sclkOut, mosiOut, busy, done, rdValid and timeoutErr are all low.
- R2: A request is taken on a clock edge where reqValid is high, busy is low and reqCmd is a valid code. The codes are 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable, 5 erase-all and 6 write-all. Code 7 is ignored: busy stays low and no done pulse follows.
- R3: From the cycle after acceptance, csOut is high and the frame is sent MSB first. The frame is a 1 start bit, a two-bit opcode (read 10, write 01, erase 11, others 00) and the six-bit address field. Each bit holds mosiOut for HALF_CYC cycles with sclkOut low and then HALF_CYC cycles with sclkOut high.
- R4: Write and write-all append the 16-bit reqData MSB first; all other commands send 9 bits only. The address field is replaced by 110000 for write-enable, 000000 for write-disable, 100000 for erase-all and 010000 for write-all.
- R5: On a read, misoIn is sampled on the last high cycle of each bit. The sample taken during the last address bit is discarded whatever its value. The next 16 samples form a word, MSB first. rdValid pulses for one cycle with that word, in the cycle after its 16th sample.
- R6: A read returns reqWords words under one chip select, with 16 more clock periods for each word and no further discarded bit. A count of 0 is treated as 1.
- R7: After the last frame bit, csOut, sclkOut and mosiOut are low for exactly GAP_CYC cycles.
- R8: After write, erase, erase-all and write-all, the gap is followed by a poll. In the poll, csOut is high, sclkOut and mosiOut are low, and misoIn is sampled every cycle. A high sample ends the poll.
- R9: If the poll samples no high level within POLL_LIMIT cycles, it ends and timeoutErr goes high. timeoutErr stays high until the next request is taken.
- R10: A poll is followed by a second low gap of GAP_CYC cycles. The command then finishes with a one-cycle done pulse, in which busy is already low. Read, write-enable and write-disable finish right after the first gap.
- R11: busy is high from the cycle after acceptance up to the done cycle. Requests presented while busy is high are ignored and cause no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqCmd | input | 3 | Command code |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | DATA_W | Word to write |
| reqWords | input | WORDS_W | Words to read (0 means 1) |
| misoIn | input | 1 | Device data-out line, synchronous to clk |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rdValid | output | 1 | Read word valid strobe |
| rdData | output | DATA_W | Read word |
| timeoutErr | output | 1 | Ready not seen within the poll limit |
| csOut | output | 1 | Chip select to the device |
| sclkOut | output | 1 | Serial clock to the device |
| mosiOut | output | 1 | Serial data to the device |

## Verification
The bench drives the device's data line high during the discarded read bit. A controller that kept that bit would return every word shifted by one position. A three-word read that crosses the top of the address space checks that no second dummy bit is expected between words; an off-by-one there misplaces rdValid and corrupts the later words. Poll cases cover a device that is ready on the first poll cycle, one that is ready on the last allowed cycle, and one that never becomes ready. A wrong limit comparison either raises timeoutErr too early or misses it. A request injected mid-command and an invalid code would each show up as a stray frame or an extra done pulse.

// File: rtl/eeHost_pkg.sv
package eeHost_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_WEN   = 3'd3,
    CMD_WDIS  = 3'd4,
    CMD_ERALL = 3'd5,
    CMD_WRALL = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FRAME, ST_GAP1, ST_POLL, ST_GAP2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new frame word
    logic shift;    // advance to the next outgoing bit
    logic sample;   // take one read data bit
    logic wordEnd;  // this sample completes a word
  } strobe_t;

endpackage

// File: rtl/eeHostCtrl.sv
module eeHostCtrl
  import eeHost_pkg::*;
#(
  parameter int HALF_CYC   = 25,
  parameter int GAP_CYC    = 25,
  parameter int POLL_LIMIT = 1000000,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int WORDS_W    = 4,
  localparam int HDR_BITS  = 3 + ADDR_W,
  localparam int FRAME_W   = HDR_BITS + DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         reqCmd,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqData,
  input  logic [WORDS_W-1:0] reqWords,
  input  logic               misoIn,
  output logic               csOut,
  output logic               sclkOut,
  output logic               inFrame,
  output logic               busy,
  output logic               done,
  output logic               timeoutErr,
  output logic [FRAME_W-1:0] frameWord,
  output strobe_t            stb
);
  localparam int LEN_W = $clog2(HDR_BITS + DATA_W * (2 ** WORDS_W)) + 1;
  localparam int HW    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int GW    = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam int PW    = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int WBW   = $clog2(DATA_W);

  state_e             state;
  logic [HW-1:0]      halfCnt;
  logic [GW-1:0]      gapCnt;
  logic [PW-1:0]      pollCnt;
  logic [LEN_W-1:0]   bitCnt, frameLen, lenNext;
  logic [WBW-1:0]     wbCnt;
  logic               sclkR, isRead, isProg, errR, doneR;
  logic               accept, cmdOk, hasData, progCmd, bitEnd;
  logic [1:0]         opBits;
  logic [ADDR_W-1:0]  addrField;
  logic [WORDS_W-1:0] nWords;

  // command decode
  always_comb begin
    cmdOk     = (reqCmd <= 3'd6);
    opBits    = 2'b00;
    addrField = '0;
    hasData   = 1'b0;
    progCmd   = 1'b0;
    case (cmd_e'(reqCmd))
      CMD_READ:  begin opBits = 2'b10; addrField = reqAddr; end
      CMD_WRITE: begin opBits = 2'b01; addrField = reqAddr; hasData = 1'b1; progCmd = 1'b1; end
      CMD_ERASE: begin opBits = 2'b11; addrField = reqAddr; progCmd = 1'b1; end
      CMD_WEN:   addrField[ADDR_W-1 -: 2] = 2'b11;
      CMD_WDIS:  addrField[ADDR_W-1 -: 2] = 2'b00;
      CMD_ERALL: begin addrField[ADDR_W-1 -: 2] = 2'b10; progCmd = 1'b1; end
      CMD_WRALL: begin addrField[ADDR_W-1 -: 2] = 2'b01; hasData = 1'b1; progCmd = 1'b1; end
      default:   opBits = 2'b00;
    endcase
    nWords = (reqWords == '0) ? WORDS_W'(1) : reqWords;
    if (reqCmd == 3'd0)
      lenNext = LEN_W'(HDR_BITS) + LEN_W'(DATA_W) * LEN_W'(nWords);
    else if (hasData)
      lenNext = LEN_W'(FRAME_W);
    else
      lenNext = LEN_W'(HDR_BITS);
    frameWord = {1'b1, opBits, addrField, hasData ? reqData : {DATA_W{1'b0}}};
  end

  assign accept = reqValid && (state == ST_IDLE) && cmdOk;
  assign bitEnd = (state == ST_FRAME) && sclkR && (halfCnt == HW'(HALF_CYC - 1));

  always_comb begin
    stb.load    = accept;
    stb.shift   = bitEnd;
    stb.sample  = bitEnd && isRead && (bitCnt >= LEN_W'(HDR_BITS));
    stb.wordEnd = stb.sample && (wbCnt == WBW'(DATA_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      halfCnt <= '0; gapCnt <= '0; pollCnt <= '0;
      bitCnt <= '0; frameLen <= '0; wbCnt <= '0;
      sclkR <= 1'b0; isRead <= 1'b0; isProg <= 1'b0;
      errR <= 1'b0; doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_FRAME;
          halfCnt  <= '0;
          sclkR    <= 1'b0;
          bitCnt   <= '0;
          wbCnt    <= '0;
          frameLen <= lenNext;
          isRead   <= (reqCmd == 3'd0);
          isProg   <= progCmd;
          errR     <= 1'b0;
        end
        ST_FRAME: begin
          if (halfCnt == HW'(HALF_CYC - 1)) begin
            halfCnt <= '0;
            sclkR   <= ~sclkR;
            if (sclkR) begin
              if (stb.sample) wbCnt <= stb.wordEnd ? '0 : wbCnt + 1'b1;
              if (bitCnt == frameLen - LEN_W'(1)) begin
                state  <= ST_GAP1;
                gapCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_GAP1: begin
          if (gapCnt == GW'(GAP_CYC - 1)) begin
            gapCnt <= '0;
            if (isProg) begin
              state   <= ST_POLL;
              pollCnt <= '0;
            end else begin
              state <= ST_IDLE;
              doneR <= 1'b1;
            end
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_POLL: begin
          if (misoIn) begin
            state <= ST_GAP2;
          end else if (pollCnt == PW'(POLL_LIMIT - 1)) begin
            state <= ST_GAP2;
            errR  <= 1'b1;
          end else begin
            pollCnt <= pollCnt + 1'b1;
          end
        end
        ST_GAP2: begin
          if (gapCnt == GW'(GAP_CYC - 1)) begin
            state <= ST_IDLE;
            doneR <= 1'b1;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csOut      = (state == ST_FRAME) || (state == ST_POLL);
  assign inFrame    = (state == ST_FRAME);
  assign sclkOut    = sclkR;
  assign busy       = (state != ST_IDLE);
  assign done       = doneR;
  assign timeoutErr = errR;

endmodule

// File: rtl/eeHostData.sv
module eeHostData
  import eeHost_pkg::*;
#(
  parameter int FRAME_W = 25,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               inFrame,
  input  logic [FRAME_W-1:0] frameWord,
  input  logic               misoIn,
  output logic               mosiOut,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData
);
  logic [FRAME_W-1:0] outSr;
  logic [DATA_W-2:0]  inSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSr   <= '0;
      inSr    <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      if (stb.load)
        outSr <= frameWord;
      else if (stb.shift)
        outSr <= {outSr[FRAME_W-2:0], 1'b0};
      if (stb.sample)
        inSr <= {inSr[DATA_W-3:0], misoIn};
      if (stb.wordEnd) begin
        rdData  <= {inSr, misoIn};
        rdValid <= 1'b1;
      end
    end
  end

  assign mosiOut = inFrame & outSr[FRAME_W-1];

endmodule

// File: rtl/eeSerialHost.sv
module eeSerialHost
  import eeHost_pkg::*;
#(
  parameter int HALF_CYC   = 25,
  parameter int GAP_CYC    = 25,
  parameter int POLL_LIMIT = 1000000,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int WORDS_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         reqCmd,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqData,
  input  logic [WORDS_W-1:0] reqWords,
  input  logic               misoIn,
  output logic               busy,
  output logic               done,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               timeoutErr,
  output logic               csOut,
  output logic               sclkOut,
  output logic               mosiOut
);
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;

  strobe_t            stb;
  logic               inFrame;
  logic [FRAME_W-1:0] frameWord;

  eeHostCtrl #(
    .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC), .POLL_LIMIT(POLL_LIMIT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS_W(WORDS_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqData(reqData), .reqWords(reqWords),
    .misoIn(misoIn), .csOut(csOut), .sclkOut(sclkOut), .inFrame(inFrame),
    .busy(busy), .done(done), .timeoutErr(timeoutErr),
    .frameWord(frameWord), .stb(stb)
  );

  eeHostData #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .inFrame(inFrame),
    .frameWord(frameWord), .misoIn(misoIn), .mosiOut(mosiOut),
    .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/eeSerialHost_chk.sv
module eeSerialHost_chk #(
  parameter int HALF_CYC = 25,
  parameter int GAP_CYC  = 25
) (
  input logic clk,
  input logic rstN,
  input logic csOut,
  input logic sclkOut,
  input logic mosiOut,
  input logic busy,
  input logic done,
  input logic rdValid
);
  logic [31:0] hiCnt, loCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt <= '0;
      loCnt <= 32'hFFFF;
    end else begin
      hiCnt <= sclkOut ? hiCnt + 1 : '0;
      if (csOut) loCnt <= '0;
      else if (loCnt != 32'hFFFF) loCnt <= loCnt + 1;
    end
  end

  // R3
  sclk_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |-> csOut);

  // R3
  sclk_high_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclkOut) |-> (hiCnt == HALF_CYC));

  // R7
  mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csOut |-> !mosiOut);

  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csOut) |-> (loCnt >= GAP_CYC));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !csOut));

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R5
  rdvalid_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> busy);

endmodule

bind eeSerialHost eeSerialHost_chk #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) chk (
  .clk(clk), .rstN(rstN), .csOut(csOut), .sclkOut(sclkOut),
  .mosiOut(mosiOut), .busy(busy), .done(done), .rdValid(rdValid)
);

// File: tb/eeSerialHost_test.sv
module eeSerialHost_test;
  localparam int H = 2;
  localparam int G = 3;
  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqCmd = '0;
  logic [5:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [3:0] reqWords = '0;
  logic misoIn = 1'b0;
  logic busy, done, rdValid, timeoutErr, csOut, sclkOut, mosiOut;
  logic [15:0] rdData;

  eeSerialHost #(.HALF_CYC(H), .GAP_CYC(G), .POLL_LIMIT(LIM),
                 .ADDR_W(6), .DATA_W(16), .WORDS_W(4)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqData(reqData), .reqWords(reqWords),
    .misoIn(misoIn), .busy(busy), .done(done), .rdValid(rdValid),
    .rdData(rdData), .timeoutErr(timeoutErr), .csOut(csOut),
    .sclkOut(sclkOut), .mosiOut(mosiOut)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic cs, sclk, mosi, miso, busy, done, rdv, err;
    logic [15:0] rdd;
  } rec_t;

  rec_t  qRec[$];
  string qTag[$];
  logic [15:0] expWords[$];
  logic [15:0] gotWords[$];
  int checks = 0, bad = 0, doneCnt = 0;
  bit run = 0, finished = 0, lastErr = 0;
  string idleTag = "R11";

  function automatic logic [15:0] memWord(int a);
    return 16'((a * 16'h1357) ^ 16'hC0DE);
  endfunction

  function automatic void pushRec(bit cs, bit sclk, bit mosi, bit miso, bit bsy,
                                  bit dn, bit rdv, logic [15:0] rdd, bit err, string tag);
    rec_t r;
    r.cs = cs; r.sclk = sclk; r.mosi = mosi; r.miso = miso; r.busy = bsy;
    r.done = dn; r.rdv = rdv; r.rdd = rdd; r.err = err;
    qRec.push_back(r);
    qTag.push_back(tag);
  endfunction

  // behavioural reference: the expected pin/status timeline from the requirements
  function automatic void plan(int cmd, int addr, logic [15:0] data, int words, int busyCyc);
    logic [1:0] op;
    logic [5:0] af;
    logic [8:0] hdr;
    bit isRead, hasData, isProg, pend, err;
    logic [15:0] pdat, word;
    int nw, n;
    op = 2'b00; af = 6'(addr);
    case (cmd)
      0: op = 2'b10;
      1: op = 2'b01;
      2: op = 2'b11;
      3: af = 6'b110000;
      4: af = 6'b000000;
      5: af = 6'b100000;
      default: af = 6'b010000;
    endcase
    hdr = {1'b1, op, af};
    isRead = (cmd == 0);
    hasData = (cmd == 1) || (cmd == 6);
    isProg = (cmd == 1) || (cmd == 2) || (cmd == 5) || (cmd == 6);
    nw = (words == 0) ? 1 : words;
    n = 9 + (isRead ? 16 * nw : (hasData ? 16 : 0));
    pend = 0; pdat = '0; err = 0; word = '0;
    for (int b = 0; b < n; b++) begin
      bit mo, mi;
      string tg;
      int w, k;
      w = 0; k = 0;
      mo = (b < 9) ? hdr[8 - b] : (hasData ? data[15 - (b - 9)] : 1'b0);
      mi = 1'b0;
      tg = (b < 9) ? "R3" : (isRead ? "R5" : "R4");
      if (isRead && b == 8) mi = 1'b1;  // dummy slot driven high: must be dropped
      if (isRead && b >= 9) begin
        w = (b - 9) / 16; k = (b - 9) % 16;
        word = memWord((addr + w) % 64);
        mi = word[15 - k];
        if (w > 0) tg = "R6";
      end
      for (int c = 0; c < 2 * H; c++) begin
        pushRec(1, c >= H, mo, mi, 1, 0, pend && c == 0, pdat, 0, tg);
        if (c == 0) pend = 0;
      end
      if (isRead && b >= 9 && k == 15) begin
        pend = 1; pdat = word; expWords.push_back(word);
      end
    end
    for (int c = 0; c < G; c++) begin
      pushRec(0, 0, 0, 0, 1, 0, pend && c == 0, pdat, 0, "R7");
      if (c == 0) pend = 0;
    end
    if (isProg) begin
      for (int k = 0; k < LIM; k++) begin
        bit rdy;
        rdy = (k >= busyCyc);
        pushRec(1, 0, 0, rdy, 1, 0, 0, '0, 0, "R8");
        if (rdy) break;
      end
      err = (busyCyc >= LIM);
      for (int c = 0; c < G; c++)
        pushRec(0, 0, 0, 0, 1, 0, 0, '0, err, err ? "R9" : "R10");
    end
    pushRec(0, 0, 0, 0, 0, 1, 0, '0, err, "R10");
    lastErr = err;
  endfunction

  // per-cycle comparison, away from the active edge
  initial forever begin
    @(negedge clk);
    if (run && !finished) begin
      rec_t e;
      string t;
      logic [6:0] act, expv;
      if (qRec.size() > 0) begin
        e = qRec.pop_front(); t = qTag.pop_front();
      end else begin
        e = '0; e.err = lastErr; t = idleTag;
      end
      misoIn = e.miso;
      act  = {csOut, sclkOut, mosiOut, busy, done, rdValid, timeoutErr};
      expv = {e.cs, e.sclk, e.mosi, e.busy, e.done, e.rdv, e.err};
      checks++;
      if (act !== expv || (e.rdv && rdData !== e.rdd)) begin
        bad++;
        $display("FAIL %s: cs/sclk/mosi/busy/done/rdv/err act=%b rd=%h exp=%b rd=%h",
                 t, act, rdData, expv, e.rdd);
      end
      if (rdValid) gotWords.push_back(rdData);
      if (done) doneCnt++;
    end
  end

  task automatic doReq(int cmd, int addr, logic [15:0] data, int words, int busyCyc, bit intrude);
    int d0;
    d0 = doneCnt;
    expWords.delete(); gotWords.delete();
    @(posedge clk); #1;
    reqValid = 1; reqCmd = 3'(cmd); reqAddr = 6'(addr); reqData = data; reqWords = 4'(words);
    @(posedge clk); #1;
    reqValid = 0;
    plan(cmd, addr, data, words, busyCyc);
    if (intrude) begin
      repeat (8) @(posedge clk);
      #1 reqValid = 1; reqCmd = 3'd0; reqAddr = 6'd5;
      @(posedge clk); #1 reqValid = 0;
    end
    while (qRec.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    checks++;
    if (gotWords.size() != expWords.size()) begin
      bad++;
      $display("FAIL R6: word count act=%0d exp=%0d", gotWords.size(), expWords.size());
    end else begin
      foreach (expWords[i]) begin
        checks++;
        if (gotWords[i] !== expWords[i]) begin
          bad++;
          $display("FAIL R5: word %0d act=%h exp=%h", i, gotWords[i], expWords[i]);
        end
      end
    end
    checks++;
    if (doneCnt != d0 + 1) begin
      bad++;
      $display("FAIL R11: done pulses act=%0d exp=%0d", doneCnt - d0, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if ({csOut, sclkOut, mosiOut, busy, done, rdValid, timeoutErr} !== 7'b0) begin
      bad++;
      $display("FAIL R1: outputs in reset act=%b exp=%b",
               {csOut, sclkOut, mosiOut, busy, done, rdValid, timeoutErr}, 7'b0);
    end
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    checks++;  // R1 first cycle after reset
    if ({csOut, sclkOut, mosiOut, busy, done, rdValid, timeoutErr} !== 7'b0) begin
      bad++;
      $display("FAIL R1: outputs after reset act=%b exp=%b",
               {csOut, sclkOut, mosiOut, busy, done, rdValid, timeoutErr}, 7'b0);
    end
    run = 1;

    doReq(3, 0, 16'h0, 0, 0, 0);            // R3/R4 write-enable pattern
    doReq(0, 6'h2A, 16'h0, 1, 0, 0);        // R5 single read
    doReq(0, 62, 16'h0, 3, 0, 0);           // R6 sequential, address wraps
    doReq(0, 7, 16'h0, 0, 0, 0);            // R6 count 0 acts as 1
    doReq(1, 6'h15, 16'hA5C3, 0, 5, 1);     // R4/R8 write + R11 request while busy
    doReq(2, 6'h33, 16'hFFFF, 0, 0, 0);     // R8 erase, ready on first poll
    doReq(5, 0, 16'h0, 0, LIM - 1, 0);      // R8 erase-all, ready on last allowed poll
    doReq(6, 0, 16'h5AF0, 0, 3, 0);         // R4 write-all
    doReq(1, 6'h01, 16'h8001, 0, LIM + 10, 0); // R9 timeout
    repeat (4) @(posedge clk);              // R9 flag holds while idle
    doReq(4, 0, 16'h0, 0, 0, 0);            // R9 cleared by next request; write-disable

    // R2 invalid code ignored
    idleTag = "R2";
    @(posedge clk); #1 reqValid = 1; reqCmd = 3'd7;
    @(posedge clk); #1 reqValid = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || doneCnt != 10) begin
      bad++;
      $display("FAIL R2: busy/doneCount act=%b/%0d exp=0/10", busy, doneCnt);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL R11: watchdog act=hung exp=complete");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule